// File: doc/BRIEF.md
# Operand Effective Address Unit

This block forms the memory operand address for the load/store stage of a CPU. It covers two register-based modes and four absolute modes. The register-based modes are post-increment and pre-decrement. The absolute modes use an 8-, 16-, 24- or 32-bit address field, and each field width is extended to the full address in its own way. The register-based modes read one of a small set of address registers kept inside the block, and they write the stepped value back. The step scales with the access size.

The block takes one request per cycle. A request carries an addressing mode, an access size, a register index, an absolute field and a flag that selects the full 32-bit space (advanced) or a 16-bit space (normal). All results come out of registers one cycle after the request. The execute stage can also load an address register directly through a separate load port.

Top module: `opnd_ea_unit`

## Requirements
- R1: Post-increment (`req_mode`=0) gives `ea` equal to the selected register and `wb_value` equal to the register plus the step. `wb_en` is 1 and `wb_reg` names the register.
- R2: Pre-decrement (`req_mode`=1) subtracts the step from the register. The difference is output both as `ea` and as `wb_value`, with `wb_en`=1.
- R3: The step is 1 when `req_size`=0 (byte), 2 when it is 1 (word) and 4 when it is 2 (longword). Code 3 acts as longword.
- R4: `misalign` is 1 only for a register-based mode with a non-byte size when bit 0 of the selected register is set. Byte accesses and absolute modes never raise it.
- R5: In the 8-bit absolute mode (`req_mode`=2), the upper address bits are filled with ones. Advanced mode gives 0xFFFFFF00..0xFFFFFFFF and normal mode gives 0xFF00..0xFFFF.
- R6: The 16-bit absolute mode (`req_mode`=3) sign-extends `abs_field[15:0]` in advanced mode. Normal mode uses it as is.
- R7: The 24-bit absolute mode (`req_mode`=4) zero-fills the top 8 bits.
- R8: The 32-bit absolute mode (`req_mode`=5) passes the field through unchanged in advanced mode.
- R9: Absolute modes give `wb_en`=0 and leave every address register unchanged. Mode codes 6 and 7 produce no output (`ea_valid`=0).
- R10: Normal mode (`adv_mode`=0) limits every `ea` and `wb_value` to 16 bits, so the upper bits are 0 and register updates wrap modulo 2^16. Advanced mode wraps modulo 2^32.
- R11: Results appear one cycle after the request with `ea_valid`=1. A write-back takes effect at that same edge, so a request to the same register in the next cycle sees the updated value.
- R12: `ld_en` writes `ld_value` into register `ld_reg`. If a write-back targets the same register in the same cycle, the write-back wins. If the two target different registers, both updates take place.
- R13: Synchronous active-high `rst` clears all eight registers and all outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing mode code |
| req_size | input | 2 | Access size code |
| req_reg | input | 3 | Address register index |
| abs_field | input | 32 | Absolute address field |
| adv_mode | input | 1 | 1 = 32-bit space, 0 = 16-bit space |
| ld_en | input | 1 | Direct register load strobe |
| ld_reg | input | 3 | Register index for the load |
| ld_value | input | 32 | Value to load |
| ea_valid | output | 1 | Result valid |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Register write-back performed |
| wb_reg | output | 3 | Register written back |
| wb_value | output | 32 | Updated register value |
| misalign | output | 1 | Non-byte access through an odd register |

## Verification
Two register updates can reach the same clock edge: the auto-modify write-back of a register-based access and a direct load from `ld_en`. The bench provokes this with a post-increment request and a load driven in the same cycle, first to the same register and then to different registers. A follow-up post-increment reads the register, and its `ea` must show the write-back value in the first case and both updates in the second. The other coincidence is a write-back followed at once by another access to the same register. Back-to-back requests check that each `ea` equals the value written by the previous cycle.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    AM_POSTINC = 3'd0,
    AM_PREDEC  = 3'd1,
    AM_ABS8    = 3'd2,
    AM_ABS16   = 3'd3,
    AM_ABS24   = 3'd4,
    AM_ABS32   = 3'd5
  } am_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } sz_e;

  function automatic logic is_reg_mode(input logic [2:0] m);
    return (m == AM_POSTINC) || (m == AM_PREDEC);
  endfunction
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int AW   = 32,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] rd_sel,
  output logic [AW-1:0] rd_data,
  input  logic          upd_en,
  input  logic [SW-1:0] upd_sel,
  input  logic [AW-1:0] upd_data,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_sel,
  input  logic [AW-1:0] ld_data
);
  logic [AW-1:0] regs [NREG];

  assign rd_data = regs[rd_sel];

  // auto-modify write-back has priority over a direct load to the same entry
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)
        regs[i] <= '0;
      else if (upd_en && upd_sel == SW'(i))
        regs[i] <= upd_data;
      else if (ld_en && ld_sel == SW'(i))
        regs[i] <= ld_data;
    end
  end
endmodule

// File: rtl/ea_autostep.sv
module ea_autostep
  import ea_pkg::*;
#(
  parameter int AW = 32,
  parameter int NW = 16
) (
  input  logic [2:0]    mode,
  input  logic [1:0]    size,
  input  logic          adv,
  input  logic [AW-1:0] rval,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] nval,
  output logic          misal
);
  localparam logic [AW-1:0] NMASK = {{(AW-NW){1'b0}}, {NW{1'b1}}};

  logic [AW-1:0] step, mask, inc, dec;

  always_comb begin
    unique case (size)
      SZ_BYTE: step = AW'(1);
      SZ_WORD: step = AW'(2);
      default: step = AW'(4);
    endcase
    mask = adv ? '1 : NMASK;
    inc  = (rval + step) & mask;
    dec  = (rval - step) & mask;
    if (mode == AM_PREDEC) begin
      addr = dec;
      nval = dec;
    end else begin
      addr = rval & mask;
      nval = inc;
    end
    misal = is_reg_mode(mode) && (size != SZ_BYTE) && rval[0];
  end
endmodule

// File: rtl/ea_abs_ext.sv
module ea_abs_ext
  import ea_pkg::*;
#(
  parameter int AW = 32,
  parameter int NW = 16
) (
  input  logic [2:0]    mode,
  input  logic          adv,
  input  logic [AW-1:0] field,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] NMASK = {{(AW-NW){1'b0}}, {NW{1'b1}}};

  logic [AW-1:0] mask;

  always_comb begin
    mask = adv ? '1 : NMASK;
    unique case (mode)
      AM_ABS8:
        addr = adv ? {{(AW-8){1'b1}}, field[7:0]}
                   : {{(AW-NW){1'b0}}, {(NW-8){1'b1}}, field[7:0]};
      AM_ABS16:
        addr = adv ? {{(AW-16){field[15]}}, field[15:0]}
                   : {{(AW-16){1'b0}}, field[15:0]} & mask;
      AM_ABS24:
        addr = {{(AW-24){1'b0}}, field[23:0]} & mask;
      default:
        addr = field & mask;
    endcase
  end
endmodule

// File: rtl/opnd_ea_unit.sv
module opnd_ea_unit
  import ea_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NW   = 16,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic [1:0]    req_size,
  input  logic [SW-1:0] req_reg,
  input  logic [AW-1:0] abs_field,
  input  logic          adv_mode,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_reg,
  input  logic [AW-1:0] ld_value,
  output logic          ea_valid,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [SW-1:0] wb_reg,
  output logic [AW-1:0] wb_value,
  output logic          misalign
);
  logic [AW-1:0] rval, step_addr, step_nval, abs_addr, ea_c;
  logic          step_misal, reg_mode, mode_ok, upd_en;

  ea_regfile #(.AW(AW), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .rd_sel   (req_reg),
    .rd_data  (rval),
    .upd_en   (upd_en),
    .upd_sel  (req_reg),
    .upd_data (step_nval),
    .ld_en    (ld_en),
    .ld_sel   (ld_reg),
    .ld_data  (ld_value)
  );

  ea_autostep #(.AW(AW), .NW(NW)) u_step (
    .mode  (req_mode),
    .size  (req_size),
    .adv   (adv_mode),
    .rval  (rval),
    .addr  (step_addr),
    .nval  (step_nval),
    .misal (step_misal)
  );

  ea_abs_ext #(.AW(AW), .NW(NW)) u_abs (
    .mode  (req_mode),
    .adv   (adv_mode),
    .field (abs_field),
    .addr  (abs_addr)
  );

  assign reg_mode = is_reg_mode(req_mode);
  assign mode_ok  = req_mode <= AM_ABS32;
  assign upd_en   = req_valid && reg_mode;
  assign ea_c     = reg_mode ? step_addr : abs_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid <= 1'b0;
      ea       <= '0;
      wb_en    <= 1'b0;
      wb_reg   <= '0;
      wb_value <= '0;
      misalign <= 1'b0;
    end else begin
      ea_valid <= req_valid && mode_ok;
      wb_en    <= upd_en;
      misalign <= req_valid && step_misal;
      if (req_valid && mode_ok) begin
        ea       <= ea_c;
        wb_reg   <= req_reg;
        wb_value <= reg_mode ? step_nval : '0;
      end
    end
  end
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int AW   = 32,
  parameter int NW   = 16,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [2:0]    req_mode,
  input logic [1:0]    req_size,
  input logic          adv_mode,
  input logic          ea_valid,
  input logic [AW-1:0] ea,
  input logic          wb_en,
  input logic [AW-1:0] wb_value,
  input logic          misalign
);
  function automatic logic [AW-1:0] stp(input logic [1:0] s);
    return (s == 2'd0) ? AW'(1) : (s == 2'd1) ? AW'(2) : AW'(4);
  endfunction

  function automatic logic [AW-1:0] msk(input logic a);
    return a ? {AW{1'b1}} : {{(AW-NW){1'b0}}, {NW{1'b1}}};
  endfunction

  p_wb_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> ea_valid);

  p_abs_no_wb_r9: assert property (@(posedge clk) disable iff (rst)
    (ea_valid && $past(req_mode) >= 3'd2) |-> !wb_en);

  p_predec_same_r2: assert property (@(posedge clk) disable iff (rst)
    (wb_en && $past(req_mode) == 3'd1) |-> (wb_value == ea));

  p_postinc_step_r1: assert property (@(posedge clk) disable iff (rst)
    (wb_en && $past(req_mode) == 3'd0)
      |-> (wb_value == ((ea + stp($past(req_size))) & msk($past(adv_mode)))));

  p_normal_narrow_r10: assert property (@(posedge clk) disable iff (rst)
    (ea_valid && !$past(adv_mode)) |-> ((ea >> NW) == '0 && (wb_value >> NW) == '0));

  p_misal_cause_r4: assert property (@(posedge clk) disable iff (rst)
    misalign |-> ($past(req_valid) && $past(req_size) != 2'd0 && $past(req_mode) <= 3'd1));

  p_abs8_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (ea_valid && $past(req_mode) == 3'd2 && $past(adv_mode)) |-> (&ea[AW-1:8]));

  p_valid_follows_r11: assert property (@(posedge clk) disable iff (rst)
    ea_valid |-> $past(req_valid));
endmodule

bind opnd_ea_unit ea_unit_chk #(.AW(AW), .NW(NW), .NREG(NREG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_mode  (req_mode),
  .req_size  (req_size),
  .adv_mode  (adv_mode),
  .ea_valid  (ea_valid),
  .ea        (ea),
  .wb_en     (wb_en),
  .wb_value  (wb_value),
  .misalign  (misalign)
);

// File: tb/test_opnd_ea_unit.sv
module test_opnd_ea_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [1:0]  req_size = '0;
  logic [2:0]  req_reg = '0;
  logic [31:0] abs_field = '0;
  logic        adv_mode = 1'b1;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_reg = '0;
  logic [31:0] ld_value = '0;
  logic        ea_valid, wb_en, misalign;
  logic [31:0] ea, wb_value;
  logic [2:0]  wb_reg;

  int total = 0;
  int bad = 0;
  logic [31:0] mdl [8];

  opnd_ea_unit i_opnd_ea_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_size(req_size), .req_reg(req_reg), .abs_field(abs_field),
    .adv_mode(adv_mode), .ld_en(ld_en), .ld_reg(ld_reg), .ld_value(ld_value),
    .ea_valid(ea_valid), .ea(ea), .wb_en(wb_en), .wb_reg(wb_reg),
    .wb_value(wb_value), .misalign(misalign)
  );

  always #10 clk = ~clk;

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_step(input logic [1:0] s);
    return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] m_mask(input logic a);
    return a ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] m_abs(input logic [2:0] m, input logic [31:0] f, input logic a);
    case (m)
      3'd2: return a ? {24'hFFFFFF, f[7:0]} : {16'h0, 8'hFF, f[7:0]};
      3'd3: return a ? {{16{f[15]}}, f[15:0]} : {16'h0, f[15:0]};
      3'd4: return {8'h0, f[23:0]} & m_mask(a);
      default: return f & m_mask(a);
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
  endtask

  task automatic load(input logic [2:0] r, input logic [31:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_reg = r; ld_value = v;
    @(posedge clk);
    #1 ld_en = 1'b0;
    mdl[r] = v;
  endtask

  // one request, optionally with a simultaneous direct load; checks all outputs
  task automatic run(input string tag, input logic [2:0] m, input logic [1:0] s,
                     input logic [2:0] r, input logic [31:0] f, input logic a,
                     input logic lo, input logic [2:0] lr, input logic [31:0] lv);
    logic [31:0] e_ea, e_wv, rv;
    logic        e_wb, e_mis, regm;
    regm = (m <= 3'd1);
    rv = mdl[r];
    e_wb = regm;
    e_mis = regm && (s != 2'd0) && rv[0];
    if (m == 3'd0) begin
      e_ea = rv & m_mask(a);
      e_wv = (rv + m_step(s)) & m_mask(a);
    end else if (m == 3'd1) begin
      e_ea = (rv - m_step(s)) & m_mask(a);
      e_wv = e_ea;
    end else begin
      e_ea = m_abs(m, f, a);
      e_wv = '0;
    end
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_size = s; req_reg = r;
    abs_field = f; adv_mode = a;
    ld_en = lo; ld_reg = lr; ld_value = lv;
    @(posedge clk);
    #1;
    req_valid = 1'b0; ld_en = 1'b0;
    if (lo) mdl[lr] = lv;
    if (regm) mdl[r] = e_wv;
    chk({tag, " ea_valid"}, {31'd0, ea_valid}, 32'd1);
    chk({tag, " ea"}, ea, e_ea);
    chk({tag, " wb_en"}, {31'd0, wb_en}, {31'd0, e_wb});
    if (regm) begin
      chk({tag, " wb_value"}, wb_value, e_wv);
      chk({tag, " wb_reg"}, {29'd0, wb_reg}, {29'd0, r});
    end
    chk({tag, " misalign"}, {31'd0, misalign}, {31'd0, e_mis});
  endtask

  task automatic t_reset();
    chk("R13 ea_valid after reset", {31'd0, ea_valid}, 32'd0);
    chk("R13 wb_en after reset", {31'd0, wb_en}, 32'd0);
    chk("R13 ea after reset", ea, 32'd0);
    for (int i = 0; i < 8; i++) run("R13 regs clear", 3'd0, 2'd0, 3'(i), 0, 1'b1, 1'b0, 0, 0);
    load(3'd5, 32'h1234_5678);
    do_reset();
    run("R13 reset wipes load", 3'd0, 2'd2, 3'd5, 0, 1'b1, 1'b0, 0, 0);
  endtask

  task automatic t_postinc();
    load(3'd1, 32'h0000_1000);
    run("R1 postinc byte", 3'd0, 2'd0, 3'd1, 0, 1'b1, 1'b0, 0, 0);
    run("R1 R3 postinc word", 3'd0, 2'd1, 3'd1, 0, 1'b1, 1'b0, 0, 0);
    run("R1 R3 postinc long", 3'd0, 2'd2, 3'd1, 0, 1'b1, 1'b0, 0, 0);
    run("R3 size code 3 as long", 3'd0, 2'd3, 3'd1, 0, 1'b1, 1'b0, 0, 0);
  endtask

  task automatic t_predec();
    load(3'd2, 32'h8000_0010);
    run("R2 predec byte", 3'd1, 2'd0, 3'd2, 0, 1'b1, 1'b0, 0, 0);
    run("R2 R3 predec word", 3'd1, 2'd1, 3'd2, 0, 1'b1, 1'b0, 0, 0);
    run("R2 R3 predec long", 3'd1, 2'd2, 3'd2, 0, 1'b1, 1'b0, 0, 0);
  endtask

  task automatic t_misalign();
    load(3'd3, 32'h0000_0101);
    run("R4 odd word flags", 3'd0, 2'd1, 3'd3, 0, 1'b1, 1'b0, 0, 0);
    load(3'd3, 32'h0000_0101);
    run("R4 odd long predec flags", 3'd1, 2'd2, 3'd3, 0, 1'b1, 1'b0, 0, 0);
    load(3'd3, 32'h0000_0101);
    run("R4 odd byte no flag", 3'd0, 2'd0, 3'd3, 0, 1'b1, 1'b0, 0, 0);
    run("R4 even word no flag", 3'd0, 2'd1, 3'd3, 0, 1'b1, 1'b0, 0, 0);
    run("R4 abs odd no flag", 3'd3, 2'd2, 3'd3, 32'h0000_0011, 1'b1, 1'b0, 0, 0);
  endtask

  task automatic t_absolute();
    run("R5 abs8 adv", 3'd2, 2'd0, 3'd0, 32'h1234_5600, 1'b1, 1'b0, 0, 0);
    run("R5 abs8 adv high", 3'd2, 2'd0, 3'd0, 32'h0000_00FF, 1'b1, 1'b0, 0, 0);
    run("R5 abs8 normal", 3'd2, 2'd0, 3'd0, 32'h0000_0042, 1'b0, 1'b0, 0, 0);
    run("R6 abs16 positive", 3'd3, 2'd1, 3'd0, 32'hABCD_7FFF, 1'b1, 1'b0, 0, 0);
    run("R6 abs16 negative", 3'd3, 2'd1, 3'd0, 32'h0000_8000, 1'b1, 1'b0, 0, 0);
    run("R6 abs16 normal", 3'd3, 2'd1, 3'd0, 32'h0000_9ABC, 1'b0, 1'b0, 0, 0);
    run("R7 abs24 adv", 3'd4, 2'd2, 3'd0, 32'hFFAB_CDEF, 1'b1, 1'b0, 0, 0);
    run("R7 abs24 normal", 3'd4, 2'd2, 3'd0, 32'hFFAB_CDEF, 1'b0, 1'b0, 0, 0);
    run("R8 abs32 adv", 3'd5, 2'd2, 3'd0, 32'hDEAD_BEEF, 1'b1, 1'b0, 0, 0);
    run("R8 R10 abs32 normal", 3'd5, 2'd2, 3'd0, 32'hDEAD_BEEF, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_no_wb();
    load(3'd4, 32'h0000_2000);
    run("R9 abs16 on r4", 3'd3, 2'd1, 3'd4, 32'h0000_1234, 1'b1, 1'b0, 0, 0);
    run("R9 abs32 on r4", 3'd5, 2'd2, 3'd4, 32'h5555_0000, 1'b1, 1'b0, 0, 0);
    run("R9 r4 untouched", 3'd0, 2'd0, 3'd4, 0, 1'b1, 1'b0, 0, 0);
    @(negedge clk);
    req_valid = 1'b1; req_mode = 3'd6; req_reg = 3'd4;
    @(posedge clk);
    #1 req_valid = 1'b0;
    chk("R9 mode 6 no valid", {31'd0, ea_valid}, 32'd0);
    chk("R9 mode 6 no wb", {31'd0, wb_en}, 32'd0);
    run("R9 r4 after mode 6", 3'd0, 2'd0, 3'd4, 0, 1'b1, 1'b0, 0, 0);
  endtask

  task automatic t_wrap();
    load(3'd6, 32'hFFFF_FFFE);
    run("R10 adv postinc wraps", 3'd0, 2'd2, 3'd6, 0, 1'b1, 1'b0, 0, 0);
    load(3'd6, 32'h0000_0000);
    run("R10 adv predec wraps", 3'd1, 2'd1, 3'd6, 0, 1'b1, 1'b0, 0, 0);
    load(3'd6, 32'h0001_FFFF);
    run("R10 normal postinc wraps", 3'd0, 2'd0, 3'd6, 0, 1'b0, 1'b0, 0, 0);
    run("R10 normal predec wraps", 3'd1, 2'd1, 3'd6, 0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_back_to_back();
    load(3'd7, 32'h0000_4000);
    for (int i = 0; i < 4; i++)
      run("R11 back-to-back postinc", 3'd0, 2'd1, 3'd7, 0, 1'b1, 1'b0, 0, 0);
    run("R11 turnaround predec", 3'd1, 2'd2, 3'd7, 0, 1'b1, 1'b0, 0, 0);
    run("R11 turnaround postinc", 3'd0, 2'd2, 3'd7, 0, 1'b1, 1'b0, 0, 0);
  endtask

  task automatic t_load_conflict();
    load(3'd1, 32'h0000_0100);
    run("R12 same reg, wb wins", 3'd0, 2'd2, 3'd1, 0, 1'b1, 1'b1, 3'd1, 32'h7777_0000);
    run("R12 read after same reg", 3'd0, 2'd0, 3'd1, 0, 1'b1, 1'b0, 0, 0);
    run("R12 different regs", 3'd0, 2'd2, 3'd1, 0, 1'b1, 1'b1, 3'd2, 32'h3333_0000);
    run("R12 load visible", 3'd0, 2'd0, 3'd2, 0, 1'b1, 1'b0, 0, 0);
    run("R12 wb visible", 3'd0, 2'd0, 3'd1, 0, 1'b1, 1'b0, 0, 0);
  endtask

  initial begin
    do_reset();
    @(posedge clk);
    #1;
    t_reset();
    t_postinc();
    t_predec();
    t_misalign();
    t_absolute();
    t_no_wb();
    t_wrap();
    t_back_to_back();
    t_load_conflict();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule